// File: doc/BRIEF.md
# Identity tree search engine

This block is the controlling end of a shared open-drain single-wire bus. It finds the 64-bit identity of every device attached to that bus. A slot sequencer does the bus timing. The engine works one level above it and asks that sequencer for three kinds of slot: a bus reset with presence sampling, a one-bit write, and a one-bit read. Each pass of the walk opens with a reset slot and then writes the search command. After that it resolves the identity one bit at a time, starting from the least significant bit.

For each bit the engine takes two read slots. The first returns the wired-AND of the bit across all devices still taking part. The second returns the wired-AND of its complement. The engine then writes the branch it chooses, and devices whose bit differs drop out of the pass.

The engine keeps two values between passes: the position of the last zero-branch discrepancy and the previous identity. With these it walks every branch of the identity tree. Every identity it finds is strobed out together with a checksum verdict. A finish pulse ends the search. It carries a flag for an empty bus or a flag for a lost response.

Top module: `idtree_scan`

## Requirements
- R1: After reset `slot_req`, `id_valid`, `fin`, `fin_empty` and `fin_lost` are 0.
- R2: A `start` pulse while idle begins a search. Every pass opens with one reset slot (`slot_kind` 0) and then eight write slots (`slot_kind` 1) that carry 0xF0 least significant bit first. `slot_wbit` is 0 whenever `slot_kind` is not 1.
- R3: If the reset slot returns `slot_rbit` 0 (no presence), the engine raises `fin` and `fin_empty` in the next cycle, emits no identity and requests no further slot.
- R4: After the command, each of the 64 identity bits takes a read slot (`slot_kind` 2), a second read slot and a write slot, in that order. A request holds `slot_kind` and `slot_wbit` steady until the cycle in which `slot_done` is 1.
- R5: When the two reads differ, the bit written is the value of the first read.
- R6: When both reads return 1, the engine raises `fin` and `fin_lost` in the next cycle and stops without emitting an identity.
- R7: When both reads return 0 at 1-based position p, and L is the last discrepancy kept from the previous pass (0 for none), the bit written is chosen as follows. If p < L it repeats the previous identity's bit. If p = L it is 1. If p > L it is 0. Whenever the chosen bit is 0, p becomes the new candidate discrepancy.
- R8: The cycle after the final write slot completes, `id_valid` is 1 for one cycle. `id_value` bit k then holds the k-th bit written, and it stays until the next identity.
- R9: `id_crc_err` is 1 with `id_valid` when the CRC-8 over bits 0..55, taken LSB first with reflected polynomial 0x8C and zero start, differs from bits 63..56.
- R10: A pass that records no zero-branch discrepancy raises `fin` in the same cycle as its `id_valid`. Otherwise a new pass begins. Across all passes every device identity is emitted exactly once.
- R11: `start` has no effect while a search is running. `fin_empty` and `fin_lost` hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search when idle |
| slot_req | output | 1 | Slot request pending |
| slot_kind | output | 2 | 0 reset, 1 write, 2 read |
| slot_wbit | output | 1 | Bit to write |
| slot_done | input | 1 | Slot completed this cycle |
| slot_rbit | input | 1 | Read bit, or presence for a reset slot |
| id_valid | output | 1 | Identity strobe |
| id_value | output | 64 | Discovered identity |
| id_crc_err | output | 1 | Checksum mismatch for `id_value` |
| fin | output | 1 | Search finished pulse |
| fin_empty | output | 1 | Search ended on an empty bus |
| fin_lost | output | 1 | Search ended on a 1/1 read pair |

## Verification
On the final pass, the identity strobe and the finish pulse fall in the same cycle. On every other pass the strobe is followed by a new reset slot instead. The bench provokes this with a lone device, with four devices whose identities share long prefixes, and with a device carrying a corrupted checksum. Slot latencies vary from one to three cycles. A behavioural model of the walk predicts both pulses, the flags and every slot request clock by clock. A set check then confirms that each device was found exactly once.

// File: rtl/idtree_scan.sv
module idtree_scan #(
  parameter int ID_W = 64,
  parameter logic [7:0] SEARCH_CMD = 8'hF0,
  parameter logic [7:0] CRC_POLY_R = 8'h8C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            slot_req,
  output logic [1:0]      slot_kind,
  output logic            slot_wbit,
  input  logic            slot_done,
  input  logic            slot_rbit,
  output logic            id_valid,
  output logic [ID_W-1:0] id_value,
  output logic            id_crc_err,
  output logic            fin,
  output logic            fin_empty,
  output logic            fin_lost
);
  localparam int CW = $clog2(ID_W);
  localparam int PW = $clog2(ID_W + 1);
  localparam logic [1:0] K_RST = 2'd0, K_WR = 2'd1, K_RD = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_CMD, S_RA, S_RB, S_WR} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [PW-1:0]  last_dis, last_zero;
  logic [ID_W-1:0] prev_id, cur_id;
  logic [7:0]     crc;
  logic           rd_a, wbit_q, dir;

  wire [PW-1:0] pos      = PW'(cnt) + PW'(1);
  wire          last_bit = cnt == CW'(ID_W - 1);
  wire          cmd_end  = cnt[2:0] == 3'd7;
  wire          disc     = rd_a == slot_rbit;
  wire [7:0]    crc_next = {1'b0, crc[7:1]} ^ ((crc[0] ^ wbit_q) ? CRC_POLY_R : 8'h00);

  always_comb begin
    if (!disc)                dir = rd_a;
    else if (pos < last_dis)  dir = prev_id[cnt];
    else                      dir = (pos == last_dis);
  end

  assign slot_req  = st != S_IDLE;
  assign slot_kind = (st == S_RST) ? K_RST : (st == S_CMD || st == S_WR) ? K_WR :
                     (st == S_RA || st == S_RB) ? K_RD : K_RST;
  assign slot_wbit = (st == S_CMD) ? SEARCH_CMD[cnt[2:0]] : (st == S_WR) ? wbit_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  last_dis <= '0;  last_zero <= '0;
      prev_id <= '0; cur_id <= '0; crc <= '0; rd_a <= 1'b0; wbit_q <= 1'b0;
      id_valid <= 1'b0; id_value <= '0; id_crc_err <= 1'b0;
      fin <= 1'b0; fin_empty <= 1'b0; fin_lost <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      fin      <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RST; last_dis <= '0; prev_id <= '0;
          fin_empty <= 1'b0; fin_lost <= 1'b0;
        end
        S_RST: if (slot_done) begin
          if (!slot_rbit) begin
            st <= S_IDLE; fin <= 1'b1; fin_empty <= 1'b1;
          end else begin
            st <= S_CMD; cnt <= '0;
          end
        end
        S_CMD: if (slot_done) begin
          if (cmd_end) begin
            st <= S_RA; cnt <= '0; last_zero <= '0; crc <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RA: if (slot_done) begin
          rd_a <= slot_rbit; st <= S_RB;
        end
        S_RB: if (slot_done) begin
          if (rd_a && slot_rbit) begin
            st <= S_IDLE; fin <= 1'b1; fin_lost <= 1'b1;
          end else begin
            wbit_q <= dir;
            if (disc && !dir) last_zero <= pos;
            st <= S_WR;
          end
        end
        S_WR: if (slot_done) begin
          cur_id[cnt] <= wbit_q;
          crc <= crc_next;
          if (last_bit) begin
            id_valid   <= 1'b1;
            id_value   <= {wbit_q, cur_id[ID_W-2:0]};
            prev_id    <= {wbit_q, cur_id[ID_W-2:0]};
            id_crc_err <= crc_next != 8'h00;
            last_dis   <= last_zero;
            if (last_zero == '0) begin
              fin <= 1'b1; st <= S_IDLE;
            end else st <= S_RST;
          end else begin
            cnt <= cnt + 1'b1; st <= S_RA;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_slot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req && !slot_done |=> slot_req && $stable(slot_kind) && $stable(slot_wbit));
  p_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RST && slot_done && !slot_rbit |=> fin && fin_empty && !id_valid);
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RB && slot_done && rd_a && slot_rbit |=> fin && fin_lost && !id_valid && !slot_req);
  p_take_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RB && slot_done && !rd_a && !slot_rbit && pos == last_dis |=> slot_wbit);
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);
  p_idle_at_fin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !slot_req && (fin_empty || fin_lost || id_valid));
endmodule

// File: tb/test_idtree_scan.sv
module test_idtree_scan;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, slot_done = 1'b0, slot_rbit = 1'b0;
  logic slot_req, slot_wbit, id_valid, id_crc_err, fin, fin_empty, fin_lost;
  logic [1:0] slot_kind;
  logic [63:0] id_value;

  idtree_scan i_idtree_scan (
    .clk(clk), .rst_n(rst_n), .start(start),
    .slot_req(slot_req), .slot_kind(slot_kind), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit),
    .id_valid(id_valid), .id_value(id_value), .id_crc_err(id_crc_err),
    .fin(fin), .fin_empty(fin_empty), .fin_lost(fin_lost));

  int vectors = 0, miscompares = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  // bus devices
  logic [63:0] sl [4];
  int nsl = 0;
  logic [3:0] part;
  int bpos = 0, rphase = 0, sidx = 0, wait_cnt = 1, nslots = 0;
  bit force_lost = 0;
  int lost_at = 0;

  task automatic serve();
    logic v;
    case (slot_kind)
      2'd0: begin
        part = 4'b0;
        for (int i = 0; i < nsl; i++) part[i] = 1'b1;
        sidx = 0; bpos = 0; rphase = 0;
        slot_rbit = (nsl > 0);
      end
      2'd1: begin
        if (sidx >= 8) begin
          for (int i = 0; i < nsl; i++) if (part[i] && sl[i][bpos] != slot_wbit) part[i] = 1'b0;
          bpos++; rphase = 0;
        end
        sidx++;
        slot_rbit = 1'b1;
      end
      default: begin
        v = 1'b1;
        for (int i = 0; i < nsl; i++) if (part[i]) v = v & (rphase == 1 ? ~sl[i][bpos] : sl[i][bpos]);
        if (force_lost && bpos == lost_at) v = 1'b1;
        slot_rbit = v;
        rphase ^= 1;
      end
    endcase
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (slot_done) slot_done = 1'b0;
      else if (rst_n && slot_req) begin
        if (wait_cnt == 0) begin
          serve();
          slot_done = 1'b1;
          nslots++;
          wait_cnt = nslots % 3;
        end else wait_cnt--;
      end
    end
  end

  // behavioural reference of the walk
  int mst = 0, mk = 0, mld = 0, mlz = 0;
  logic [63:0] mprev = '0, mid = '0, eid = '0;
  logic ma = 0, mdir = 0, ev = 0, ecrc = 0, efin = 0, eempty = 0, elost = 0;
  logic [63:0] found [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; ev = 0; efin = 0; eempty = 0; elost = 0; eid = '0; ecrc = 0;
    end else begin
      ev = 0; efin = 0;
      case (mst)
        0: if (start) begin mst = 1; mld = 0; mprev = '0; eempty = 0; elost = 0; end
        1: if (slot_done) begin
          if (!slot_rbit) begin mst = 0; efin = 1; eempty = 1; end
          else begin mst = 2; mk = 0; end
        end
        2: if (slot_done) begin
          if (mk == 7) begin mst = 3; mk = 0; mlz = 0; end else mk++;
        end
        3: if (slot_done) begin ma = slot_rbit; mst = 4; end
        4: if (slot_done) begin
          if (ma && slot_rbit) begin mst = 0; efin = 1; elost = 1; end
          else begin
            if (ma != slot_rbit) mdir = ma;
            else if (mk + 1 < mld) mdir = mprev[mk];
            else mdir = (mk + 1 == mld);
            if (ma == slot_rbit && !mdir) mlz = mk + 1;
            mst = 5;
          end
        end
        5: if (slot_done) begin
          mid[mk] = mdir;
          if (mk == 63) begin
            ev = 1; eid = mid; ecrc = crc8(mid[55:0]) != mid[63:56];
            mld = mlz; mprev = mid;
            if (mlz == 0) begin efin = 1; mst = 0; end else mst = 1;
          end else begin mk++; mst = 3; end
        end
        default: mst = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic ereq, ewb;
      logic [1:0] ekind;
      ereq = mst != 0;
      ekind = (mst == 1) ? 2'd0 : (mst == 2 || mst == 5) ? 2'd1 : (mst == 3 || mst == 4) ? 2'd2 : 2'd0;
      ewb = (mst == 2) ? ((8'hF0 >> mk) & 1) != 0 : (mst == 5) ? mdir : 1'b0;
      chk(slot_req == ereq, "R2/R4 slot_req", 64'(slot_req), 64'(ereq));
      if (ereq) chk(slot_kind == ekind, "R2/R4 slot_kind", 64'(slot_kind), 64'(ekind));
      chk(slot_wbit == ewb, "R5/R7 slot_wbit", 64'(slot_wbit), 64'(ewb));
      chk(id_valid == ev, "R8 id_valid", 64'(id_valid), 64'(ev));
      chk(fin == efin, "R10 fin", 64'(fin), 64'(efin));
      chk(fin_empty == eempty, "R3 fin_empty", 64'(fin_empty), 64'(eempty));
      chk(fin_lost == elost, "R6 fin_lost", 64'(fin_lost), 64'(elost));
      if (ev) begin
        chk(id_value == eid, "R8 id_value", id_value, eid);
        chk(id_crc_err == ecrc, "R9 id_crc_err", 64'(id_crc_err), 64'(ecrc));
      end
      if (id_valid) found.push_back(id_value);
    end
  end

  task automatic run(input int busy_start_at);
    found.delete();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 40000 && !fin; c++) begin
      @(negedge clk);
      if (c == busy_start_at) start = 1'b1;   // R11: ignored while running
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_set();
    for (int i = 0; i < nsl; i++) begin
      int hits = 0;
      foreach (found[j]) if (found[j] == sl[i]) hits++;
      chk(hits == 1, "R10 each device found once", 64'(hits), 64'd1);
    end
    chk(found.size() == nsl, "R10 identity count", 64'(found.size()), 64'(nsl));
  endtask

  function automatic logic [63:0] mk_id(input logic [55:0] low);
    return {crc8(low), low};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!slot_req && !id_valid && !fin && !fin_empty && !fin_lost, "R1 reset outputs",
        {59'd0, slot_req, id_valid, fin, fin_empty, fin_lost}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    nsl = 0; run(-1);                                   // R3 empty bus
    chk(fin_empty == 1'b1, "R3 empty flag held", 64'(fin_empty), 64'd1);
    chk(found.size() == 0, "R3 no identity", 64'(found.size()), 64'd0);

    nsl = 1; sl[0] = mk_id(56'h12_3456_789A_BC01); run(-1);   // R8 R9 R10 lone device
    check_set();

    sl[0] = mk_id(56'h00_00C0_FFEE_0028) ^ 64'h0100_0000_0000_0000; run(-1); // R9 bad checksum
    check_set();

    nsl = 4;                                            // R7 branching walk, R11 busy start
    sl[0] = mk_id(56'h12_3456_789A_BC01);
    sl[1] = mk_id(56'h12_3456_789A_BC03);
    sl[2] = mk_id(56'hA5_0000_0000_0011);
    sl[3] = mk_id(56'h00_0000_0000_0010);
    run(300);
    check_set();

    nsl = 2; force_lost = 1; lost_at = 10; run(-1);    // R6 lost response
    chk(fin_lost == 1'b1, "R6 lost flag held", 64'(fin_lost), 64'd1);
    force_lost = 0;

    nsl = 3; sl[2] = mk_id(56'hFF_FFFF_FFFF_FFFF); run(-1);  // R2 R11 flags cleared on restart
    chk(fin_lost == 1'b0, "R11 lost flag cleared", 64'(fin_lost), 64'd0);
    check_set();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule